// File: doc/BRIEF.md
# Residual Voltage Fault Monitor

This block supervises the residual-voltage comparators of three regulator rails. Each rail has a tick-driven timer that counts how long its comparator has stayed high; the timer returns to zero as soon as the comparator drops. From these timers and the current sequencing context, the block does four things. It raises sticky per-rail fault flags. It holds power-up off while a rail still carries charge. It aborts a running sequence. It asks the power sequencer to fall back to the initialize state.

The power sequencer tells the block which phase it is in through a context code. The phases are: an ON request while in the initialize state, power-up, active-to-standby, standby-to-active, and leaving standby. The sequencer also passes a mask of the rails that were off during standby. A per-rail pulse reports a command that enables a single rail. Software clears flags by writing ones. A single global bit suppresses only the interrupt pin: the flags are always set, and the summary source bit follows the pin.

Top module: `rv_guard`

## Requirements
- R1: `pwrup_gate` is high while `ctx` = 1 (ON request in initialize) and any `rail_rv` bit is high. It is low in every other case, so clearing the comparators releases power-up.
- R2: In `ctx` = 1, a rail whose comparator stays high for `FLAG_TICKS` (4) `ms_tick` pulses has its `rv_flag` bit (bit i = rail i) set on the clock edge after the counting edge of the last tick. With fewer ticks the bit stays clear.
- R3: When a rail's comparator goes low, its timer restarts from zero, so the ticks before the drop do not count toward any threshold.
- R4: `seq_abort` is high while `ctx` is 2 (power-up), 3 (active-to-standby) or 4 (standby-to-active) and any `rail_rv` bit is high. It is low in the other contexts.
- R5: In `ctx` = 5 (leaving standby), a rail marked in `stby_off` whose comparator stays high sets its flag after 4 ticks. It raises `goto_init` once it has reached `LONG_TICKS` (80) ticks. Rails not marked in `stby_off` neither set flags nor raise `goto_init` in this context.
- R6: A pulse on `i2c_en[i]` while `rail_rv[i]` is high sets `rv_flag[i]` on the next edge, whatever the timer holds. It causes no `seq_abort`, `goto_init` or `pwrup_gate`. Without residual voltage on that rail, the pulse has no effect.
- R7: `int_n` (active low) is low exactly when some flag is set and `int_mask` is 0. `int_mask` has no effect on whether flags are set.
- R8: `rv_src` is high exactly when `int_n` is asserted.
- R9: A one in `flag_clr[i]` clears `rv_flag[i]` on the next edge. A set condition in the same cycle wins over the clear. Flags are otherwise sticky.
- R10: After synchronous reset, all flags and timers are zero, `int_n` is high, and `pwrup_gate`, `seq_abort` and `goto_init` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle millisecond tick |
| rail_rv | input | NRAIL | Residual-voltage comparator per rail |
| ctx | input | 3 | Sequencing context code (0 idle, 1 init ON, 2 power-up, 3 act-to-stby, 4 stby-to-act, 5 leave stby) |
| stby_off | input | NRAIL | Rails that were off during standby |
| i2c_en | input | NRAIL | Pulse: command enables rail i |
| int_mask | input | 1 | Global interrupt-pin mask for residual faults |
| flag_clr | input | NRAIL | Write-one-to-clear for the flags |
| rv_flag | output | NRAIL | Sticky per-rail residual-voltage flags |
| rv_src | output | 1 | Summary interrupt source bit |
| int_n | output | 1 | Interrupt pin, active low |
| pwrup_gate | output | 1 | Holds power-up off |
| seq_abort | output | 1 | Aborts the running sequence |
| goto_init | output | 1 | Requests transition to initialize |

## Verification
The assertions check on every cycle the following properties. A flag can rise only after its comparator was high. A flag can fall only after a clear write. The pin stays quiet while masked, and it is never asserted without a flag. The transition request is never made without preceding residual voltage. Abort and power-up gating are never active together. Only the directed scenarios can show the threshold counts: the fourth tick sets the flag while the third does not, and the eightieth tick raises the request while the seventy-ninth does not. The same holds for the timer restart after a comparator drop, the set-over-clear priority, and the exclusion of rails that stayed on in standby.

// File: rtl/rvg_pkg.sv
package rvg_pkg;
    typedef enum logic [2:0] {
        CTX_IDLE     = 3'd0,
        CTX_INIT_ON  = 3'd1,
        CTX_PWR_UP   = 3'd2,
        CTX_ACT2STBY = 3'd3,
        CTX_STBY2ACT = 3'd4,
        CTX_LEAVE    = 3'd5
    } ctx_e;

    function automatic logic is_seq_ctx(input ctx_e c);
        return (c == CTX_PWR_UP) || (c == CTX_ACT2STBY) || (c == CTX_STBY2ACT);
    endfunction

    // Timed flag window applies to this rail in this context
    function automatic logic timed_ok(input ctx_e c, input logic off_in_stby);
        return (c == CTX_INIT_ON) || ((c == CTX_LEAVE) && off_in_stby);
    endfunction
endpackage

// File: rtl/rvg_timer.sv
module rvg_timer #(
    parameter int LIMIT = 80,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          rv,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] SAT = CW'(LIMIT);

    always_ff @(posedge clk) begin
        if (rst || !rv) begin
            cnt <= '0;
        end else if (tick && cnt != SAT) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rvg_flag.sv
module rvg_flag #(
    parameter int FLAG_TICKS = 4,
    parameter int CW         = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  rvg_pkg::ctx_e ctx,
    input  logic          rv,
    input  logic          off_in_stby,
    input  logic          i2c_en,
    input  logic          clr,
    input  logic [CW-1:0] cnt,
    output logic          flag
);
    localparam logic [CW-1:0] THR = CW'(FLAG_TICKS);

    logic set_now;

    always_comb begin
        set_now = rv && ((rvg_pkg::timed_ok(ctx, off_in_stby) && cnt >= THR) || i2c_en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set_now) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/rvg_decide.sv
module rvg_decide #(
    parameter int NRAIL = 3
) (
    input  rvg_pkg::ctx_e    ctx,
    input  logic [NRAIL-1:0] rail_rv,
    input  logic [NRAIL-1:0] long_hit,
    input  logic [NRAIL-1:0] flags,
    input  logic             int_mask,
    output logic             pwrup_gate,
    output logic             seq_abort,
    output logic             goto_init,
    output logic             int_n,
    output logic             rv_src
);
    logic any_rv;
    logic pin_on;

    always_comb begin
        any_rv     = |rail_rv;
        pwrup_gate = (ctx == rvg_pkg::CTX_INIT_ON) && any_rv;
        seq_abort  = rvg_pkg::is_seq_ctx(ctx) && any_rv;
        goto_init  = (ctx == rvg_pkg::CTX_LEAVE) && (|long_hit);
        pin_on     = (|flags) && !int_mask;
        int_n      = !pin_on;
        rv_src     = pin_on;
    end
endmodule

// File: rtl/rv_guard.sv
module rv_guard #(
    parameter int NRAIL      = 3,
    parameter int FLAG_TICKS = 4,
    parameter int LONG_TICKS = 80
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ms_tick,
    input  logic [NRAIL-1:0] rail_rv,
    input  logic [2:0]       ctx,
    input  logic [NRAIL-1:0] stby_off,
    input  logic [NRAIL-1:0] i2c_en,
    input  logic             int_mask,
    input  logic [NRAIL-1:0] flag_clr,
    output logic [NRAIL-1:0] rv_flag,
    output logic             rv_src,
    output logic             int_n,
    output logic             pwrup_gate,
    output logic             seq_abort,
    output logic             goto_init
);
    localparam int CW = $clog2(LONG_TICKS + 1);
    localparam logic [CW-1:0] LONG_V = CW'(LONG_TICKS);

    rvg_pkg::ctx_e    ctx_q;
    logic [NRAIL-1:0] long_hit;

    assign ctx_q = rvg_pkg::ctx_e'(ctx);

    for (genvar i = 0; i < NRAIL; i++) begin : g_rail
        logic [CW-1:0] cnt;

        rvg_timer #(.LIMIT(LONG_TICKS), .CW(CW)) u_tmr (
            .clk (clk),
            .rst (rst),
            .tick(ms_tick),
            .rv  (rail_rv[i]),
            .cnt (cnt)
        );

        rvg_flag #(.FLAG_TICKS(FLAG_TICKS), .CW(CW)) u_flg (
            .clk        (clk),
            .rst        (rst),
            .ctx        (ctx_q),
            .rv         (rail_rv[i]),
            .off_in_stby(stby_off[i]),
            .i2c_en     (i2c_en[i]),
            .clr        (flag_clr[i]),
            .cnt        (cnt),
            .flag       (rv_flag[i])
        );

        assign long_hit[i] = stby_off[i] && rail_rv[i] && (cnt == LONG_V);
    end

    rvg_decide #(.NRAIL(NRAIL)) u_dec (
        .ctx       (ctx_q),
        .rail_rv   (rail_rv),
        .long_hit  (long_hit),
        .flags     (rv_flag),
        .int_mask  (int_mask),
        .pwrup_gate(pwrup_gate),
        .seq_abort (seq_abort),
        .goto_init (goto_init),
        .int_n     (int_n),
        .rv_src    (rv_src)
    );
endmodule

// File: rtl/rvg_checker.sv
module rvg_checker #(
    parameter int NRAIL = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [NRAIL-1:0] rail_rv,
    input logic [NRAIL-1:0] flag_clr,
    input logic             int_mask,
    input logic [NRAIL-1:0] rv_flag,
    input logic             rv_src,
    input logic             int_n,
    input logic             pwrup_gate,
    input logic             seq_abort,
    input logic             goto_init
);
    p_flag_rise_r2: assert property (@(posedge clk) disable iff (rst)
        (rv_flag & ~$past(rv_flag) & ~$past(rail_rv)) == '0);

    p_flag_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (~rv_flag & $past(rv_flag) & ~$past(flag_clr)) == '0);

    p_pin_masked_r7: assert property (@(posedge clk) disable iff (rst)
        int_mask |-> int_n);

    p_pin_needs_flag_r7: assert property (@(posedge clk) disable iff (rst)
        !int_n |-> (rv_flag != '0));

    p_src_unmasked_r8: assert property (@(posedge clk) disable iff (rst)
        rv_src |-> !int_mask);

    p_goto_past_rv_r5: assert property (@(posedge clk) disable iff (rst)
        goto_init |-> ($past(rail_rv) != '0));

    p_abort_vs_gate_r4: assert property (@(posedge clk) disable iff (rst)
        !(seq_abort && pwrup_gate));
endmodule

bind rv_guard rvg_checker #(.NRAIL(NRAIL)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rail_rv   (rail_rv),
    .flag_clr  (flag_clr),
    .int_mask  (int_mask),
    .rv_flag   (rv_flag),
    .rv_src    (rv_src),
    .int_n     (int_n),
    .pwrup_gate(pwrup_gate),
    .seq_abort (seq_abort),
    .goto_init (goto_init)
);

// File: tb/rv_guard_test.sv
module rv_guard_test;
    localparam int NR = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ms_tick = 1'b0;
    logic [NR-1:0] rail_rv = '0;
    logic [2:0]    ctx = 3'd0;
    logic [NR-1:0] stby_off = '0;
    logic [NR-1:0] i2c_en = '0;
    logic          int_mask = 1'b0;
    logic [NR-1:0] flag_clr = '0;
    logic [NR-1:0] rv_flag;
    logic          rv_src, int_n, pwrup_gate, seq_abort, goto_init;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    rv_guard uut (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .rail_rv(rail_rv), .ctx(ctx),
        .stby_off(stby_off), .i2c_en(i2c_en), .int_mask(int_mask), .flag_clr(flag_clr),
        .rv_flag(rv_flag), .rv_src(rv_src), .int_n(int_n), .pwrup_gate(pwrup_gate),
        .seq_abort(seq_abort), .goto_init(goto_init)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic tick_n(input int n);
        for (int k = 0; k < n; k++) begin
            ms_tick = 1'b1;
            step();
            ms_tick = 1'b0;
            step();
        end
    endtask

    task automatic clear_all();
        rail_rv = '0;
        step();
        flag_clr = '1;
        step();
        flag_clr = '0;
        ctx = 3'd0;
        stby_off = '0;
        step();
    endtask

    task automatic t_reset();
        check("R10 flags", 32'(rv_flag), 0);
        check("R10 int_n", 32'(int_n), 1);
        check("R10 gate", 32'(pwrup_gate), 0);
        check("R10 abort", 32'(seq_abort), 0);
        check("R10 goto", 32'(goto_init), 0);
    endtask

    task automatic t_init_on();
        ctx = 3'd1;
        rail_rv = 3'b010;
        #1;
        check("R1 gate on", 32'(pwrup_gate), 1);
        check("R4 no abort in init", 32'(seq_abort), 0);
        step();
        tick_n(3);
        check("R2 no flag at 3 ticks", 32'(rv_flag), 0);
        tick_n(1);
        check("R2 flag at 4 ticks", 32'(rv_flag), 32'h2);
        check("R7 pin asserted", 32'(int_n), 0);
        check("R8 src set", 32'(rv_src), 1);
        rail_rv = '0;
        #1;
        check("R1 gate released", 32'(pwrup_gate), 0);
        step();
        check("R9 flag sticky", 32'(rv_flag), 32'h2);
        flag_clr = 3'b010;
        step();
        flag_clr = '0;
        check("R9 cleared", 32'(rv_flag), 0);
        check("R7 pin released", 32'(int_n), 1);
        clear_all();
    endtask

    task automatic t_restart();
        ctx = 3'd1;
        rail_rv = 3'b001;
        step();
        tick_n(3);
        rail_rv = '0;
        step();
        rail_rv = 3'b001;
        step();
        tick_n(3);
        check("R3 restart no flag", 32'(rv_flag), 0);
        tick_n(1);
        check("R3 flag after fresh 4", 32'(rv_flag), 32'h1);
        clear_all();
    endtask

    task automatic t_seq();
        for (int c = 2; c <= 4; c++) begin
            ctx = 3'(c);
            rail_rv = 3'b100;
            #1;
            check("R4 abort", 32'(seq_abort), 1);
            check("R1 no gate in seq", 32'(pwrup_gate), 0);
            step();
            rail_rv = '0;
            #1;
            check("R4 abort clears", 32'(seq_abort), 0);
            step();
        end
        ctx = 3'd0;
        rail_rv = 3'b100;
        #1;
        check("R4 no abort idle", 32'(seq_abort), 0);
        clear_all();
    endtask

    task automatic t_mask();
        int_mask = 1'b1;
        ctx = 3'd1;
        rail_rv = 3'b001;
        step();
        tick_n(4);
        check("R7 flag despite mask", 32'(rv_flag), 32'h1);
        check("R7 pin masked", 32'(int_n), 1);
        check("R8 src follows pin", 32'(rv_src), 0);
        int_mask = 1'b0;
        #1;
        check("R7 pin unmasked", 32'(int_n), 0);
        check("R8 src on", 32'(rv_src), 1);
        clear_all();
    endtask

    task automatic t_leave();
        ctx = 3'd5;
        stby_off = 3'b001;
        rail_rv = 3'b011;
        step();
        tick_n(4);
        check("R5 flag only off rail", 32'(rv_flag), 32'h1);
        check("R5 no goto early", 32'(goto_init), 0);
        tick_n(75);
        check("R5 no goto at 79", 32'(goto_init), 0);
        tick_n(1);
        check("R5 goto at 80", 32'(goto_init), 1);
        check("R5 on-rail no flag", 32'(rv_flag), 32'h1);
        rail_rv = 3'b010;
        step();
        check("R5 goto drops", 32'(goto_init), 0);
        clear_all();
    endtask

    task automatic t_i2c();
        rail_rv = 3'b100;
        i2c_en = 3'b101;
        #1;
        check("R6 no abort", 32'(seq_abort), 0);
        check("R6 no gate", 32'(pwrup_gate), 0);
        check("R6 no goto", 32'(goto_init), 0);
        step();
        i2c_en = '0;
        check("R6 flag immediate", 32'(rv_flag), 32'h4);
        clear_all();
    endtask

    task automatic t_set_wins();
        rail_rv = 3'b001;
        i2c_en = 3'b001;
        step();
        flag_clr = 3'b001;
        step();
        i2c_en = '0;
        flag_clr = '0;
        check("R9 set beats clear", 32'(rv_flag), 32'h1);
        clear_all();
        check("R9 clear alone", 32'(rv_flag), 0);
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        t_reset();
        t_init_on();
        t_restart();
        t_seq();
        t_mask();
        t_leave();
        t_i2c();
        t_set_wins();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule